// File: doc/BRIEF.md
# Interrupt Request Output Controller

This block collects a vector of status events into one active-low interrupt request. Each event sets a sticky latch on its rising edge. Software reads the latches, enables sources through a mask, and releases them through write-one-to-clear bits. A 2-bit duration field makes the request either a pulse of 3, 15 or 63 reference-clock cycles or a level that holds until the event is cleared or masked. A software stimulus bit can force the request on whatever the sources are doing.

The pad is modelled as a drive value and an output enable. The output comes out of reset in open-drain form, so it floats until it has a request to signal. Push-pull low-active and push-pull high-active drive become available once a drive mode is written.

Registers are reached through a byte-wide port with a combinational read. A page field at address 0x0E, bits 6:5, selects the register space. Value 01 maps addresses 0x40 to 0x4C onto the interrupt registers. Address 0x0E itself can be reached from every page.

Top module: `irq_request_ctrl`

## Requirements
- R1: After reset, every source is masked (0x42 reads 0), the duration field is 00, the drive field is 00 (open drain), the page field is 00, and the pad output enable is 0.
- R2: A rising edge on event input i sets bit i of the raw register (0x41). The bit stays set after the input falls.
- R3: Writing 1 to bit i of the clear register (0x43) clears raw bit i. If a rising edge of event i arrives in the same cycle as the clear, the edge wins and the bit stays set.
- R4: Config register 0x40 holds duration in bits 7:6, drive mode in bits 5:4 and the stimulus in bit 0. An unmasked rising edge with duration 00, 01 or 10 asserts the request for exactly 3, 15 or 63 cycles, starting in the cycle after the edge is sampled.
- R5: An event whose mask bit (0x42, 1 = enabled) is 0 produces no request, but it still sets its raw bit.
- R6: An unmasked rising edge that arrives while a pulse is running restarts the full duration.
- R7: With duration 11, the request stays asserted while any raw bit that is also unmasked is set, even after the event input falls. It releases once that bit is cleared or masked.
- R8: Drive mode 00 or 11 is open drain: the output enable equals the request and the value is 0. Mode 01 drives the inverted request. Mode 10 drives the request itself. In both push-pull modes the output enable is 1.
- R9: While the stimulus bit is 1, the request is asserted whatever the events and masks are.
- R10: Only page value 01 maps addresses 0x40 to 0x4C onto the interrupt registers. On any other page, writes there are ignored and reads there return 0. Address 0x0E reads back the page in bits 6:5 on every page, and a new page applies from the next access.
- R11: Register 0x44 reads the pending set, which is the raw bits ANDed with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_EVT | Event status inputs |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when 1, read when 0 |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| irq_pad_o | output | 1 | Pad drive value |
| irq_pad_oe | output | 1 | Pad output enable |

## Verification
Register writes and event edges are sampled at the rising edge. Raw bits, configuration and the page become visible right after that edge, and the pad follows combinationally. A pulse therefore covers the N falling edges that follow the edge which sampled the event. The bench drives inputs on falling edges and samples results on the next falling edge, or a short delay after it for reads. For every pulse it counts the low cycles in a window longer than the duration and compares the count with 3, 15 or 63, or with the stretched total after a retrigger.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    DUR_3    = 2'b00,
    DUR_15   = 2'b01,
    DUR_63   = 2'b10,
    DUR_HOLD = 2'b11
  } dur_sel_e;

  typedef enum logic [1:0] {
    DRV_OD      = 2'b00,
    DRV_PP_LOW  = 2'b01,
    DRV_PP_HIGH = 2'b10,
    DRV_OD_ALT  = 2'b11
  } drv_sel_e;

  localparam int CNT_W = 6;

  localparam logic [7:0] ADDR_PAGE  = 8'h0E;
  localparam logic [7:0] ADDR_CFG   = 8'h40;
  localparam logic [7:0] ADDR_RAW   = 8'h41;
  localparam logic [7:0] ADDR_MASK  = 8'h42;
  localparam logic [7:0] ADDR_CLR   = 8'h43;
  localparam logic [7:0] ADDR_PEND  = 8'h44;
  localparam logic [7:0] ADDR_LAST  = 8'h4C;
  localparam logic [1:0] PAGE_IRQ   = 2'b01;

  // Pulse length in reference-clock cycles; 0 means level (held) mode.
  function automatic logic [CNT_W-1:0] pulse_len(dur_sel_e s);
    case (s)
      DUR_3:   return CNT_W'(3);
      DUR_15:  return CNT_W'(15);
      DUR_63:  return CNT_W'(63);
      default: return '0;
    endcase
  endfunction

  function automatic logic is_open_drain(drv_sel_e m);
    return (m == DRV_OD) || (m == DRV_OD_ALT);
  endfunction
endpackage

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] mask_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] raw_o,
  output logic [NUM_EVT-1:0] pend_o,
  output logic [NUM_EVT-1:0] rise_o
);
  logic [NUM_EVT-1:0] prev_q;

  assign rise_o = evt_i & ~prev_q;
  assign pend_o = raw_o & mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      raw_o  <= '0;
    end else begin
      prev_q <= evt_i;
      raw_o  <= (raw_o & ~clr_i) | rise_o;
    end
  end

  // R3
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((raw_o & $past(rise_o)) == $past(rise_o)));

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_o & ~clr_i)) |=> ((raw_o & $past(raw_o & ~clr_i)) == $past(raw_o & ~clr_i)));
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer
  import irq_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     trig_i,
  input  dur_sel_e dur_i,
  output logic     active_o
);
  logic [CNT_W-1:0] cnt_q;

  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (trig_i)       cnt_q <= pulse_len(dur_i);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && dur_i != DUR_HOLD) |=> active_o);

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && active_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/irq_pad_drive.sv
module irq_pad_drive
  import irq_ctrl_pkg::*;
(
  input  drv_sel_e drv_i,
  input  logic     req_i,
  output logic     pad_o,
  output logic     pad_oe
);
  always_comb begin
    case (drv_i)
      DRV_PP_LOW:  begin pad_o = ~req_i; pad_oe = 1'b1;  end
      DRV_PP_HIGH: begin pad_o = req_i;  pad_oe = 1'b1;  end
      default:     begin pad_o = 1'b0;   pad_oe = req_i; end
    endcase
  end
endmodule

// File: rtl/irq_request_ctrl.sv
module irq_request_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               reg_en,
  input  logic               reg_we,
  input  logic [7:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq_pad_o,
  output logic               irq_pad_oe
);
  logic [1:0]         page_q;
  dur_sel_e           dur_q;
  drv_sel_e           drv_q;
  logic               stim_q;
  logic [NUM_EVT-1:0] mask_q;

  logic               wr_stb;
  logic               irq_space;
  logic [NUM_EVT-1:0] clr_vec;
  logic [NUM_EVT-1:0] raw_vec;
  logic [NUM_EVT-1:0] pend_vec;
  logic [NUM_EVT-1:0] rise_vec;
  logic               pulse_trig;
  logic               pulse_active;
  logic               irq_req;

  assign wr_stb    = reg_en && reg_we;
  assign irq_space = (page_q == PAGE_IRQ) && (reg_addr >= ADDR_CFG) && (reg_addr <= ADDR_LAST);
  assign clr_vec   = (wr_stb && irq_space && reg_addr == ADDR_CLR) ? reg_wdata[NUM_EVT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 2'b00;
      dur_q  <= DUR_3;
      drv_q  <= DRV_OD;
      stim_q <= 1'b0;
      mask_q <= '0;
    end else if (wr_stb) begin
      if (reg_addr == ADDR_PAGE) page_q <= reg_wdata[6:5];
      if (irq_space && reg_addr == ADDR_CFG) begin
        dur_q  <= dur_sel_e'(reg_wdata[7:6]);
        drv_q  <= drv_sel_e'(reg_wdata[5:4]);
        stim_q <= reg_wdata[0];
      end
      if (irq_space && reg_addr == ADDR_MASK) mask_q <= reg_wdata[NUM_EVT-1:0];
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == ADDR_PAGE) begin
      reg_rdata = {1'b0, page_q, 5'b0};
    end else if (irq_space) begin
      case (reg_addr)
        ADDR_CFG:  reg_rdata = {dur_q, drv_q, 3'b000, stim_q};
        ADDR_RAW:  reg_rdata = 8'(raw_vec);
        ADDR_MASK: reg_rdata = 8'(mask_q);
        ADDR_PEND: reg_rdata = 8'(pend_vec);
        default:   reg_rdata = 8'h00;
      endcase
    end
  end

  irq_event_bank #(.NUM_EVT(NUM_EVT)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .mask_i (mask_q),
    .clr_i  (clr_vec),
    .raw_o  (raw_vec),
    .pend_o (pend_vec),
    .rise_o (rise_vec)
  );

  assign pulse_trig = |(rise_vec & mask_q);

  irq_pulse_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (pulse_trig),
    .dur_i    (dur_q),
    .active_o (pulse_active)
  );

  assign irq_req = stim_q | ((dur_q == DUR_HOLD) ? (|pend_vec) : pulse_active);

  irq_pad_drive u_pad (
    .drv_i  (drv_q),
    .req_i  (irq_req),
    .pad_o  (irq_pad_o),
    .pad_oe (irq_pad_oe)
  );

  // R7
  held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dur_q == DUR_HOLD && (|pend_vec)) |-> irq_req);

  // R10
  page_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_addr == ADDR_PAGE) |=> (page_q == $past(reg_wdata[6:5])));

  // R8
  od_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_open_drain(drv_q) && !irq_req) |-> !irq_pad_oe);

  // R9
  stim_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stim_q |-> irq_req);
endmodule

// File: tb/tb_irq_request_ctrl.sv
module tb_irq_request_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NEV = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NEV-1:0] evt = '0;
  logic           reg_en = 1'b0;
  logic           reg_we = 1'b0;
  logic [7:0]     reg_addr = 8'h00;
  logic [7:0]     reg_wdata = 8'h00;
  logic [7:0]     reg_rdata;
  logic           pad_o;
  logic           pad_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_request_ctrl #(.NUM_EVT(NEV)) dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pad_o(pad_o), .irq_pad_oe(pad_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1;
    d = reg_rdata;
    reg_en = 1'b0;
  endtask

  // cfg byte: dur[7:6] drv[5:4] stim[0]
  task automatic cfg(input logic [1:0] dur, input logic [1:0] drv, input logic stim);
    wr(8'h40, {dur, drv, 3'b000, stim});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 oe after reset", int'(pad_oe), 0);
    rd(8'h0E, d); check("R1 page reset", int'(d), 0);
  endtask

  task automatic t_page();
    logic [7:0] d;
    wr(8'h40, 8'h10);
    check("R10 write ignored on page 00 (oe)", int'(pad_oe), 0);
    rd(8'h40, d); check("R10 read on page 00", int'(d), 0);
    wr(8'h0E, 8'h20);
    rd(8'h0E, d); check("R10 page readback", int'(d), 8'h20);
    rd(8'h40, d); check("R1 cfg reset value", int'(d), 0);
    rd(8'h42, d); check("R1 mask reset value", int'(d), 0);
    wr(8'h40, 8'h10);
    check("R10 write on page 01 drives pad", int'(pad_oe), 1);
    wr(8'h0E, 8'h40);
    rd(8'h40, d); check("R10 page 10 hides cfg", int'(d), 0);
    wr(8'h0E, 8'h20);
    rd(8'h40, d); check("R10 back to page 01", int'(d), 8'h10);
  endtask

  task automatic t_pulse(input logic [1:0] dur, input int n);
    int lows = 0;
    cfg(dur, 2'b01, 1'b0);
    wr(8'h42, 8'h01);
    @(negedge clk); evt[0] = 1'b1;
    for (int j = 0; j < n + 4; j++) begin
      @(negedge clk);
      if (j == 0) begin
        evt[0] = 1'b0;
        check("R4 pulse starts after edge", int'(pad_o), 0);
      end
      if (pad_o == 1'b0) lows++;
    end
    check($sformatf("R4 pulse length dur=%0d", dur), lows, n);
  endtask

  task automatic t_retrigger();
    int lows = 0;
    cfg(2'b00, 2'b01, 1'b0);
    wr(8'h42, 8'h03);
    @(negedge clk); evt[0] = 1'b1;
    for (int j = 0; j < 9; j++) begin
      @(negedge clk);
      if (j == 1) evt[1] = 1'b1;
      if (pad_o == 1'b0) lows++;
    end
    evt = '0;
    check("R6 retrigger stretches to 5 cycles", lows, 5);
  endtask

  task automatic t_masked();
    logic [7:0] d;
    int lows = 0;
    wr(8'h43, 8'hFF);
    wr(8'h42, 8'h00);
    @(negedge clk); evt[1] = 1'b1;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      evt[1] = 1'b0;
      if (pad_o == 1'b0) lows++;
    end
    check("R5 masked event no request", lows, 0);
    rd(8'h41, d); check("R2 raw bit sticky after fall", int'(d), 8'h02);
    rd(8'h44, d); check("R11 pending empty when masked", int'(d), 0);
    wr(8'h42, 8'h02);
    rd(8'h44, d); check("R11 pending after unmask", int'(d), 8'h02);
    wr(8'h42, 8'h00);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(8'h43, 8'hFF);
    rd(8'h41, d); check("R3 clear all", int'(d), 0);
    @(negedge clk); evt = 8'h0C;
    @(negedge clk); evt = 8'h00;
    @(negedge clk);
    evt[2] = 1'b1;
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = 8'h43; reg_wdata = 8'h0C;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0; evt[2] = 1'b0;
    rd(8'h41, d); check("R3 edge beats same-cycle clear", int'(d), 8'h04);
    wr(8'h43, 8'hFF);
  endtask

  task automatic t_held();
    cfg(2'b11, 2'b01, 1'b0);
    wr(8'h42, 8'h01);
    @(negedge clk); evt[0] = 1'b1;
    @(negedge clk); evt[0] = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 held after event falls", int'(pad_o), 0);
    wr(8'h43, 8'h01);
    check("R7 released by clear", int'(pad_o), 1);
    @(negedge clk); evt[0] = 1'b1;
    @(negedge clk); evt[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 held again", int'(pad_o), 0);
    wr(8'h42, 8'h00);
    check("R7 released by mask", int'(pad_o), 1);
    wr(8'h43, 8'hFF);
  endtask

  task automatic t_drive();
    cfg(2'b00, 2'b00, 1'b1);
    check("R9 stim od oe", int'(pad_oe), 1);
    check("R8 od value", int'(pad_o), 0);
    cfg(2'b00, 2'b00, 1'b0);
    check("R8 od idle floats", int'(pad_oe), 0);
    cfg(2'b00, 2'b10, 1'b1);
    check("R8 pp high asserted", int'(pad_o), 1);
    check("R8 pp high oe", int'(pad_oe), 1);
    cfg(2'b00, 2'b10, 1'b0);
    check("R8 pp high idle", int'(pad_o), 0);
    check("R8 pp high idle oe", int'(pad_oe), 1);
    cfg(2'b00, 2'b11, 1'b1);
    check("R8 mode 11 asserted oe", int'(pad_oe), 1);
    cfg(2'b00, 2'b11, 1'b0);
    check("R8 mode 11 idle floats", int'(pad_oe), 0);
    cfg(2'b00, 2'b01, 1'b1);
    check("R9 stim pp low", int'(pad_o), 0);
    cfg(2'b00, 2'b01, 1'b0);
    check("R8 pp low idle", int'(pad_o), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page();
    t_pulse(2'b00, 3);
    t_pulse(2'b01, 15);
    t_pulse(2'b10, 63);
    t_retrigger();
    t_masked();
    t_clear();
    t_held();
    t_drive();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule